// File: doc/BRIEF.md
# Breakpoint Address Range Matcher

This block compares one memory access or instruction fetch against four breakpoint entries and reports, one bit per entry, which of them the access has struck. Each entry holds a linear address, a two-bit type code that selects which kinds of access it watches, and a two-bit length code that sets the size of the watched field. The access is described by its linear address, its size in bytes and its kind.

A data entry watches an aligned field of one, two or four bytes. The length code clears low address bits of the entry address to force the alignment. The entry strikes when any byte of the access lands inside that field. An execution entry watches the first byte of an instruction only. It strikes when a fetch starts exactly at its address. The block does no enable gating, records no status and does no address translation. The hit vector is formed combinationally and registered once, so it appears one clock after the access is presented.

Top module: `bp_range_match`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `hit` is all zeros after that edge, whatever the entry and access inputs are.
- R2: `hit` after a rising edge reflects the entry and access inputs sampled at that edge: one cycle of latency, no other state.
- R3: Length code 00 selects a one-byte field at the entry address. Code 01 selects a two-byte field with address bit 0 forced to zero. Code 11 selects a four-byte field with address bits 1:0 forced to zero.
- R4: A data entry strikes when the access bytes [addr, addr+size-1] overlap its field. The address does not wrap past the top of the address space.
- R5: Type code 01 strikes on writes only. Type code 11 strikes on reads and writes. Neither strikes on a fetch. Access kind is encoded 00 fetch, 01 read, 10 write.
- R6: Type code 00 with length code 00 strikes only on a fetch whose address equals the entry address in every bit. The fetch size does not change the result.
- R7: Type code 10 and length code 10 never strike. A type 00 entry with any length code other than 00 never strikes.
- R8: An access with size other than 1, 2 or 4, or with kind code 11, strikes no entry.
- R9: Each entry is judged on its own: several bits of `hit` may be set at once, and no enable gates any bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_addr | input | ADDR_W | Linear address of the access |
| acc_size | input | 3 | Access size in bytes (1, 2 or 4) |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 reserved |
| bp_addr | input | N_ENTRIES*ADDR_W | Entry addresses, entry i at bits [i*ADDR_W +: ADDR_W] |
| bp_type | input | N_ENTRIES*2 | Entry type codes, entry i at bits [2i+1:2i] |
| bp_len | input | N_ENTRIES*2 | Entry length codes, entry i at bits [2i+1:2i] |
| hit | output | N_ENTRIES | Registered strike vector, one bit per entry |

## Verification
The hardest case to reach is a partial overlap between a multi-byte access and a field whose entry address is misaligned. This case needs the masking and the range compare to work together. Random addresses over a wide space almost never produce it. The stimulus therefore places the entries and the accesses inside one sixteen-byte window, so random sizes and offsets keep falling on field edges. Directed steps then cover the exact edge cases: one byte short of a field, one byte into it, and a field at address zero with an access that would wrap from the top.

// File: rtl/bp_match_pkg.sv
package bp_match_pkg;

  // Access kind codes
  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_READ  = 2'b01;
  localparam logic [1:0] KIND_WRITE = 2'b10;
  localparam logic [1:0] KIND_RSVD  = 2'b11;

  // Entry type codes
  localparam logic [1:0] TYPE_EXEC  = 2'b00;
  localparam logic [1:0] TYPE_WR    = 2'b01;
  localparam logic [1:0] TYPE_RSVD  = 2'b10;
  localparam logic [1:0] TYPE_RW    = 2'b11;

  // Entry length codes
  localparam logic [1:0] LEN_ONE    = 2'b00;
  localparam logic [1:0] LEN_TWO    = 2'b01;
  localparam logic [1:0] LEN_RSVD   = 2'b10;
  localparam logic [1:0] LEN_FOUR   = 2'b11;

  // Low address bits cleared by a length code
  function automatic logic [1:0] len_clear_bits(input logic [1:0] len);
    case (len)
      LEN_TWO:  return 2'b01;
      LEN_FOUR: return 2'b11;
      default:  return 2'b00;
    endcase
  endfunction

  // Offset of the last byte of the field from its base
  function automatic logic [1:0] len_last_offset(input logic [1:0] len);
    case (len)
      LEN_TWO:  return 2'd1;
      LEN_FOUR: return 2'd3;
      default:  return 2'd0;
    endcase
  endfunction

  function automatic logic size_is_legal(input logic [2:0] size);
    return (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
  endfunction

  // Does a data entry type watch this kind of access
  function automatic logic data_kind_pass(input logic [1:0] typ, input logic [1:0] kind);
    case (typ)
      TYPE_WR: return kind == KIND_WRITE;
      TYPE_RW: return (kind == KIND_READ) || (kind == KIND_WRITE);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bp_access_decode.sv
module bp_access_decode
  import bp_match_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int EXT_W = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_size,
  input  logic [1:0]        acc_kind,
  output logic [EXT_W-1:0]  acc_first,
  output logic [EXT_W-1:0]  acc_last,
  output logic              acc_ok
);

  // One extra bit keeps the last byte from wrapping to address zero
  always_comb begin
    acc_first = {1'b0, acc_addr};
    acc_last  = acc_first + EXT_W'(acc_size) - EXT_W'(1);
    acc_ok    = size_is_legal(acc_size) && (acc_kind != KIND_RSVD);
  end

endmodule

// File: rtl/bp_entry_cmp.sv
module bp_entry_cmp
  import bp_match_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int EXT_W = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic [1:0]        bp_type,
  input  logic [1:0]        bp_len,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic [EXT_W-1:0]  acc_first,
  input  logic [EXT_W-1:0]  acc_last,
  input  logic              acc_ok,
  output logic              entry_hit
);

  logic [ADDR_W-1:0] keep_mask;
  logic [EXT_W-1:0]  field_base;
  logic [EXT_W-1:0]  field_last;
  logic              bytes_overlap;
  logic              exec_strike;
  logic              data_strike;

  always_comb begin
    keep_mask     = {{(ADDR_W-2){1'b1}}, ~len_clear_bits(bp_len)};
    field_base    = {1'b0, bp_addr & keep_mask};
    field_last    = field_base + EXT_W'(len_last_offset(bp_len));
    bytes_overlap = (acc_first <= field_last) && (field_base <= acc_last);

    exec_strike   = acc_ok && (bp_type == TYPE_EXEC) && (bp_len == LEN_ONE) &&
                    (acc_kind == KIND_FETCH) && (acc_addr == bp_addr);

    data_strike   = acc_ok && (bp_len != LEN_RSVD) &&
                    data_kind_pass(bp_type, acc_kind) && bytes_overlap;

    entry_hit     = exec_strike || data_strike;
  end

endmodule

// File: rtl/bp_range_match.sv
module bp_range_match
  import bp_match_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int N_ENTRIES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             acc_addr,
  input  logic [2:0]                    acc_size,
  input  logic [1:0]                    acc_kind,
  input  logic [N_ENTRIES*ADDR_W-1:0]   bp_addr,
  input  logic [N_ENTRIES*2-1:0]        bp_type,
  input  logic [N_ENTRIES*2-1:0]        bp_len,
  output logic [N_ENTRIES-1:0]          hit
);

  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0]     acc_first;
  logic [EXT_W-1:0]     acc_last;
  logic                 acc_ok;
  logic [N_ENTRIES-1:0] hit_next;

  bp_access_decode #(.ADDR_W(ADDR_W)) u_decode (
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_kind  (acc_kind),
    .acc_first (acc_first),
    .acc_last  (acc_last),
    .acc_ok    (acc_ok)
  );

  for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_entry
    bp_entry_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .bp_addr   (bp_addr[gi*ADDR_W +: ADDR_W]),
      .bp_type   (bp_type[gi*2 +: 2]),
      .bp_len    (bp_len[gi*2 +: 2]),
      .acc_addr  (acc_addr),
      .acc_kind  (acc_kind),
      .acc_first (acc_first),
      .acc_last  (acc_last),
      .acc_ok    (acc_ok),
      .entry_hit (hit_next[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hit <= '0;
    else        hit <= hit_next;
  end

endmodule

// File: rtl/bp_range_match_chk.sv
module bp_range_match_chk
  import bp_match_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int N_ENTRIES = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           acc_addr,
  input logic [2:0]                  acc_size,
  input logic [1:0]                  acc_kind,
  input logic [N_ENTRIES*ADDR_W-1:0] bp_addr,
  input logic [N_ENTRIES*2-1:0]      bp_type,
  input logic [N_ENTRIES*2-1:0]      bp_len,
  input logic [N_ENTRIES-1:0]        hit
);

  // R1: reset clears the vector
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> hit == '0);

  // R8: illegal size or reserved kind strikes nothing
  p_bad_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!((acc_size == 3'd1) || (acc_size == 3'd2) || (acc_size == 3'd4)) ||
     acc_kind == KIND_RSVD) |=> hit == '0);

  for (genvar gi = 0; gi < N_ENTRIES; gi++) begin : g_chk
    // R7: reserved type never strikes
    p_rsvd_type_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bp_type[gi*2 +: 2] == TYPE_RSVD |=> !hit[gi]);

    // R7: reserved length never strikes
    p_rsvd_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bp_len[gi*2 +: 2] == LEN_RSVD |=> !hit[gi]);

    // R7: execution entry with a length other than one byte never strikes
    p_exec_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_type[gi*2 +: 2] == TYPE_EXEC && bp_len[gi*2 +: 2] != LEN_ONE) |=> !hit[gi]);

    // R5: data entries ignore fetches
    p_fetch_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == KIND_FETCH && bp_type[gi*2 +: 2] != TYPE_EXEC) |=> !hit[gi]);

    // R5: write-only entries ignore reads
    p_read_wronly_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == KIND_READ && bp_type[gi*2 +: 2] == TYPE_WR) |=> !hit[gi]);

    // R6: execution entries need an exact address and a fetch
    p_exec_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_type[gi*2 +: 2] == TYPE_EXEC &&
       (acc_kind != KIND_FETCH || acc_addr != bp_addr[gi*ADDR_W +: ADDR_W])) |=> !hit[gi]);
  end

endmodule

bind bp_range_match bp_range_match_chk #(
  .ADDR_W    (ADDR_W),
  .N_ENTRIES (N_ENTRIES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_addr (acc_addr),
  .acc_size (acc_size),
  .acc_kind (acc_kind),
  .bp_addr  (bp_addr),
  .bp_type  (bp_type),
  .bp_len   (bp_len),
  .hit      (hit)
);

// File: tb/test_bp_range_match.sv
module test_bp_range_match;

  localparam int AW = 32;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [2:0]    acc_size = 3'd1;
  logic [1:0]    acc_kind = 2'd1;
  logic [NE*AW-1:0] bp_addr = '0;
  logic [NE*2-1:0]  bp_type = '0;
  logic [NE*2-1:0]  bp_len  = '0;
  logic [NE-1:0]    hit;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bp_range_match #(.ADDR_W(AW), .N_ENTRIES(NE)) i_bp_range_match (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_size(acc_size),
    .acc_kind(acc_kind), .bp_addr(bp_addr), .bp_type(bp_type),
    .bp_len(bp_len), .hit(hit)
  );

  // Behavioural model: walk the bytes of the access one at a time
  function automatic bit model_entry(longint ba, int t, int l, longint a, int s, int k);
    longint flen, base;
    if (k == 3) return 0;
    if (!(s == 1 || s == 2 || s == 4)) return 0;
    if (t == 2 || l == 2) return 0;
    if (t == 0) return (l == 0) && (k == 0) && (a == ba);
    if (k == 0) return 0;
    if (t == 1 && k != 2) return 0;
    flen = (l == 0) ? 1 : ((l == 1) ? 2 : 4);
    base = ba - (ba % flen);
    for (int b = 0; b < s; b++) begin
      if ((a + b) >= base && (a + b) < base + flen) return 1;
    end
    return 0;
  endfunction

  function automatic logic [NE-1:0] model_vec();
    logic [NE-1:0] v;
    for (int i = 0; i < NE; i++)
      v[i] = model_entry(longint'(bp_addr[i*AW +: AW]), int'(bp_type[i*2 +: 2]),
                         int'(bp_len[i*2 +: 2]), longint'(acc_addr),
                         int'(acc_size), int'(acc_kind));
    return v;
  endfunction

  task automatic set_entry(int i, longint a, int t, int l);
    bp_addr[i*AW +: AW] = AW'(a);
    bp_type[i*2 +: 2]   = 2'(t);
    bp_len[i*2 +: 2]    = 2'(l);
  endtask

  // Drive at a falling edge, compare one clock later at the next falling edge
  task automatic step(string tag, longint a, int s, int k);
    logic [NE-1:0] exp;
    acc_addr = AW'(a);
    acc_size = 3'(s);
    acc_kind = 2'(k);
    exp = model_vec();
    @(negedge clk);
    checks++;
    if (hit !== exp) begin
      errors++;
      $display("FAIL %s: addr=%h size=%0d kind=%0d hit=%b expected %b",
               tag, acc_addr, s, k, hit, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: matching inputs during reset must not show
    set_entry(0, 'h100, 3, 0);
    set_entry(1, 'h100, 3, 0);
    set_entry(2, 'h100, 3, 0);
    set_entry(3, 'h100, 3, 0);
    acc_addr = 'h100; acc_size = 3'd1; acc_kind = 2'd1;
    repeat (3) @(negedge clk);
    checks++;
    if (hit !== '0) begin
      errors++;
      $display("FAIL R1: hit=%b expected 0000 in reset", hit);
    end
    rst_n = 1'b1;
    // R2 / R9: first cycle after reset, all four entries strike together
    step("R2 R9 all entries", 'h100, 1, 1);
    step("R2 next access misses", 'h200, 1, 1);

    // R3 / R4: byte-field and overlap cases
    set_entry(0, 'hA0001, 3, 0);
    set_entry(1, 'hA0002, 3, 0);
    set_entry(2, 'hB0002, 3, 1);
    set_entry(3, 'hC0000, 3, 3);
    step("R4 byte A0001",      'hA0001, 1, 1);
    step("R4 byte A0002",      'hA0002, 1, 2);
    step("R4 word A0001",      'hA0001, 2, 1);
    step("R4 word A0002",      'hA0002, 2, 1);
    step("R3 word field",      'hB0002, 2, 2);
    step("R4 dword B0001",     'hB0001, 4, 1);
    step("R3 dword field",     'hC0000, 4, 1);
    step("R4 word C0001",      'hC0001, 2, 1);
    step("R4 byte C0003",      'hC0003, 1, 2);
    step("R4 miss A0000",      'hA0000, 1, 1);
    step("R4 miss A0003",      'hA0003, 4, 1);
    step("R4 miss B0000",      'hB0000, 2, 1);
    step("R4 miss C0004",      'hC0004, 4, 1);
    // R3: misaligned entry addresses are masked
    set_entry(2, 'hB0003, 3, 1);
    set_entry(3, 'hC0002, 3, 3);
    step("R3 masked word",     'hB0002, 1, 1);
    step("R3 masked dword",    'hC0000, 1, 1);
    // R4: no wrap at the top of the address space
    set_entry(0, 'h0, 3, 3);
    step("R4 no wrap",         'hFFFF_FFFF, 2, 1);
    step("R4 top byte",        'hFFFF_FFFC, 4, 1);

    // R5: type filtering
    set_entry(0, 'h300, 1, 0);
    set_entry(1, 'h300, 3, 0);
    set_entry(2, 'h300, 1, 3);
    set_entry(3, 'h300, 3, 3);
    step("R5 write",           'h300, 1, 2);
    step("R5 read",            'h300, 1, 1);
    step("R5 fetch on data",   'h300, 1, 0);

    // R6: execution entries
    set_entry(0, 'h401, 0, 0);
    set_entry(1, 'h400, 0, 0);
    set_entry(2, 'h402, 0, 0);
    set_entry(3, 'h401, 3, 0);
    step("R6 exact fetch",     'h401, 1, 0);
    step("R6 size ignored",    'h401, 4, 0);
    step("R6 overlap no",      'h400, 4, 0);
    step("R6 read at exec",    'h401, 1, 1);

    // R7: reserved and inconsistent codes
    set_entry(0, 'h500, 2, 0);
    set_entry(1, 'h500, 3, 2);
    set_entry(2, 'h500, 0, 1);
    set_entry(3, 'h500, 0, 3);
    step("R7 data read",       'h500, 1, 1);
    step("R7 write",           'h500, 4, 2);
    step("R7 fetch",           'h500, 1, 0);

    // R8: illegal access descriptions
    set_entry(0, 'h600, 3, 3);
    set_entry(1, 'h600, 3, 0);
    set_entry(2, 'h601, 3, 0);
    set_entry(3, 'h600, 0, 0);
    step("R8 size 3",          'h600, 3, 1);
    step("R8 size 0",          'h600, 0, 1);
    step("R8 kind 11",         'h600, 1, 3);
    step("R8 legal control",   'h600, 2, 1);

    // R4 / R9: dense random window
    for (int n = 0; n < 600; n++) begin
      int sz;
      if (n % 8 == 0)
        for (int e = 0; e < NE; e++)
          set_entry(e, 'hA0000 + longint'($urandom_range(0, 15)),
                    int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      case ($urandom_range(0, 4))
        0: sz = 1; 1: sz = 2; 2: sz = 4; 3: sz = 4; default: sz = 3;
      endcase
      step("R4 R9 random", 'hA0000 + longint'($urandom_range(0, 15)), sz,
           int'($urandom_range(0, 3)));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule